// File: doc/BRIEF.md
# Dual-Pair Carrier Generator

This block makes a square carrier. Each period has a high phase and a low phase, and each phase lasts a programmed number of clock cycles. Two count pairs hold these lengths. The primary pair resets to zero. The alternate pair keeps its contents through reset. Software writes the four 8-bit counts over a byte-wide write port.

In plain timing mode only the primary pair is used. In keyed mode an external modulator drives a select line, and that line chooses which pair sets each new period. The block takes a copy of the chosen counts when a period starts. Register writes and select changes made during a period therefore never shorten or stretch that period. A phase whose count is zero is skipped. If the generator runs in keyed mode while either alternate count is zero, a status flag is raised.

Top module: `cgen_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `carrier` and `cfg_err` are low. Reset clears the primary counts to zero, so a generator enabled in timing mode after reset keeps `carrier` low.
- R2: In timing mode (`fsk_mode`=0), each period is `carrier` high for the primary high count and then low for the primary low count, in clock cycles, and periods follow back to back. `alt_sel` is ignored in this mode.
- R3: After an edge that samples `gen_en` low, `carrier` is low. The first edge that samples `gen_en` high starts a new period, beginning with its high phase.
- R4: In keyed mode (`fsk_mode`=1), `alt_sel` is sampled at the edge that starts each period: 0 picks the primary pair and 1 picks the alternate pair.
- R5: A change of `alt_sel` during a period takes effect only at the next period start. The running period keeps its full length.
- R6: A count written during a running period takes effect from the next period onward.
- R7: A phase whose count is zero is skipped. If both counts of the chosen pair are zero, `carrier` stays low and the pair is read again every cycle.
- R8: The alternate counts keep their values through reset.
- R9: `cfg_err` is a registered flag. At each edge it takes the value (`gen_en` and `fsk_mode` and at least one alternate count equal to zero), so it shows that condition one cycle later.
- R10: Address map for `wr_addr`: 0 = primary high count, 1 = primary low count, 2 = alternate high count, 3 = alternate low count. A write lands when `wr_en` is high at a clock edge. Writes are ignored while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the count registers |
| wr_addr | input | 2 | Count register address |
| wr_data | input | 8 | Count value to write |
| gen_en | input | 1 | Generator enable |
| fsk_mode | input | 1 | 0 = timing mode, 1 = keyed mode |
| alt_sel | input | 1 | Pair select from the modulator (keyed mode) |
| carrier | output | 1 | Carrier output |
| cfg_err | output | 1 | Keyed mode enabled with a zero alternate count |

## Verification
The bench builds the block with its default 8-bit counts and a 2-bit address. It uses small programmed counts between zero and five, so every period is a few cycles long. Many period starts therefore fit in a short run, including a zero-length phase, both phases at zero and every pair switch between consecutive periods. Small counts also place mid-period writes and select changes early in a period. That makes it plain whether the running period was cut short or the new value was held back to the next one.

// File: rtl/cgen_pkg.sv
package cgen_pkg;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 2;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        cnt_t hi;
        cnt_t lo;
    } pair_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    localparam addr_t A_PRI_HI = addr_t'(0);
    localparam addr_t A_PRI_LO = addr_t'(1);
    localparam addr_t A_ALT_HI = addr_t'(2);
    localparam addr_t A_ALT_LO = addr_t'(3);

    // Pair that governs the next period.
    function automatic pair_t pick_pair(pair_t pri, pair_t alt, logic keyed, logic sel);
        return (keyed && sel) ? alt : pri;
    endfunction

    function automatic logic pair_has_zero(pair_t p);
        return (p.hi == '0) || (p.lo == '0);
    endfunction

endpackage

// File: rtl/cgen_bank.sv
module cgen_bank
    import cgen_pkg::*;
#(
    parameter bit    KEEP_ON_RESET = 1'b0,
    parameter addr_t HI_ADDR       = A_PRI_HI,
    parameter addr_t LO_ADDR       = A_PRI_LO
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  cnt_t  wr_data,
    output pair_t pair_q
);

    generate
        if (KEEP_ON_RESET) begin : g_keep
            // Contents survive reset; writes are only blocked during it.
            always_ff @(posedge clk) begin
                if (wr_en && !rst) begin
                    if (wr_addr == HI_ADDR) pair_q.hi <= wr_data;
                    if (wr_addr == LO_ADDR) pair_q.lo <= wr_data;
                end
            end
        end else begin : g_clear
            always_ff @(posedge clk) begin
                if (rst) begin
                    pair_q <= '0;
                end else if (wr_en) begin
                    if (wr_addr == HI_ADDR) pair_q.hi <= wr_data;
                    if (wr_addr == LO_ADDR) pair_q.lo <= wr_data;
                end
            end
        end
    endgenerate

    // R10: without a write strobe the pair holds its value
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pair_q));

endmodule

// File: rtl/cgen_core.sv
module cgen_core
    import cgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  pair_t next_pair,
    output logic  carrier
);

    phase_e phase;
    cnt_t   cnt;
    pair_t  snap;
    logic   last_cycle;
    logic   period_end;
    logic   fetch;

    assign last_cycle = (cnt == cnt_t'(1));
    assign period_end = last_cycle &&
                        ((phase == PH_LOW) || (phase == PH_HIGH && snap.lo == '0));
    assign fetch      = (phase == PH_IDLE) || period_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            snap  <= '0;
        end else if (!en) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (fetch) begin
            snap <= next_pair;
            if (next_pair.hi != '0) begin
                phase <= PH_HIGH;
                cnt   <= next_pair.hi;
            end else if (next_pair.lo != '0) begin
                phase <= PH_LOW;
                cnt   <= next_pair.lo;
            end else begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end
        end else if (last_cycle) begin
            phase <= PH_LOW;
            cnt   <= snap.lo;
        end else begin
            cnt <= cnt_t'(cnt - cnt_t'(1));
        end
    end

    assign carrier = (phase == PH_HIGH);

    // R1: reset returns the phase machine to idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (phase == PH_IDLE));

    // R3: a disabled generator is idle after the edge
    p_off_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase == PH_IDLE));

    // R2: an active phase always has cycles left
    p_cnt_live_r2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (cnt != '0));

    // R7: zero-length phases are never entered
    p_skip_high_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH) |-> (snap.hi != '0));
    p_skip_low_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> (snap.lo != '0));

    // R6/R5: the captured pair is frozen until the period ends
    p_snap_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (en && phase != PH_IDLE && !period_end) |=> $stable(snap));

endmodule

// File: rtl/cgen_top.sv
module cgen_top
    import cgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       gen_en,
    input  logic       fsk_mode,
    input  logic       alt_sel,
    output logic       carrier,
    output logic       cfg_err
);

    pair_t pri_pair;
    pair_t alt_pair;
    pair_t next_pair;
    logic  err_q;

    cgen_bank #(
        .KEEP_ON_RESET (1'b0),
        .HI_ADDR       (A_PRI_HI),
        .LO_ADDR       (A_PRI_LO)
    ) i_pri_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (addr_t'(wr_addr)),
        .wr_data (cnt_t'(wr_data)),
        .pair_q  (pri_pair)
    );

    cgen_bank #(
        .KEEP_ON_RESET (1'b1),
        .HI_ADDR       (A_ALT_HI),
        .LO_ADDR       (A_ALT_LO)
    ) i_alt_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (addr_t'(wr_addr)),
        .wr_data (cnt_t'(wr_data)),
        .pair_q  (alt_pair)
    );

    assign next_pair = pick_pair(pri_pair, alt_pair, fsk_mode, alt_sel);

    cgen_core i_core (
        .clk       (clk),
        .rst       (rst),
        .en        (gen_en),
        .next_pair (next_pair),
        .carrier   (carrier)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= gen_en && fsk_mode && pair_has_zero(alt_pair);
    end

    assign cfg_err = err_q;

    // R9: keyed mode with a zero alternate count raises the flag next cycle
    p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
        (gen_en && fsk_mode && pair_has_zero(alt_pair)) |=> cfg_err);

    // R9: the flag is never up without the enable
    p_err_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> !cfg_err);

endmodule

// File: tb/test_cgen_top.sv
module test_cgen_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       gen_en = 1'b0;
    logic       fsk_mode = 1'b0;
    logic       alt_sel = 1'b0;
    logic       carrier;
    logic       cfg_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    cgen_top i_cgen_top (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .gen_en   (gen_en),
        .fsk_mode (fsk_mode),
        .alt_sel  (alt_sel),
        .carrier  (carrier),
        .cfg_err  (cfg_err)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    logic  exp_q[$];
    string tag = "";
    int    sh[4] = '{0, 0, 0, 0};

    task automatic chk(bit ok, string t, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Monitor: compares each carrier cycle with the scoreboard.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            chk(carrier === e, tag, int'(carrier), int'(e));
        end
    end

    // All tasks assume they start one time unit after a rising edge.
    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        if (!rst) sh[a] = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Driver: pushes one expected period, sets the select for the next one,
    // optionally writes a register mid-period.
    task automatic period(string t, logic nsel, bit do_w = 1'b0, int a = 0, int d = 0);
        int h, l, len;
        if (fsk_mode && alt_sel) begin h = sh[2]; l = sh[3]; end
        else begin h = sh[0]; l = sh[1]; end
        len = (h + l == 0) ? 1 : h + l;
        tag = t;
        for (int i = 0; i < h; i++) exp_q.push_back(1'b1);
        for (int i = 0; i < l; i++) exp_q.push_back(1'b0);
        if (h + l == 0) exp_q.push_back(1'b0);
        alt_sel = nsel;
        if (do_w) begin
            wr(a, d);
            repeat (len - 1) @(posedge clk);
        end else begin
            repeat (len) @(posedge clk);
        end
        #1;
    endtask

    task automatic start(logic keyed, logic s);
        fsk_mode = keyed; alt_sel = s; gen_en = 1'b1;
        @(posedge clk); #1;
    endtask

    // R3: disabling forces the carrier low after one edge
    task automatic stop();
        gen_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(carrier === 1'b0, "R3 carrier low when disabled", int'(carrier), 0);
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(carrier === 1'b0, "R1 carrier in reset", int'(carrier), 0);
        chk(cfg_err === 1'b0, "R1 flag in reset", int'(cfg_err), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(carrier === 1'b0, "R1 carrier after reset", int'(carrier), 0);
        chk(cfg_err === 1'b0, "R1 flag after reset", int'(cfg_err), 0);
        @(posedge clk); #1;

        // R1: primary counts cleared, carrier stays low when enabled
        start(1'b0, 1'b0);
        repeat (3) period("R1 primary cleared", 1'b0);
        stop();

        // R2 and R10: timing mode from primary pair, select ignored
        wr(0, 3); wr(1, 2);
        start(1'b0, 1'b1);
        period("R2 timing mode", 1'b1);
        period("R2 timing mode, select ignored", 1'b0);
        period("R2 timing mode", 1'b1);
        // R6: mid-period write to primary high count
        period("R6 write during period", 1'b0, 1'b1, 0, 1);
        period("R6 new count next period", 1'b0);
        period("R6 new count next period", 1'b0);
        stop();

        // R3: restart begins with a high phase
        start(1'b0, 1'b0);
        period("R3 restart", 1'b0);
        period("R3 restart", 1'b0);
        stop();

        // R4 and R5: keyed mode, pair chosen per period
        wr(2, 2); wr(3, 4);
        start(1'b1, 1'b0);
        period("R4 primary pair", 1'b1);
        period("R4 alternate pair", 1'b0);
        period("R5 select change mid-period", 1'b1);
        period("R5 select change mid-period", 1'b1);
        period("R4 alternate pair again", 1'b0);
        period("R6 alternate write mid-period", 1'b1, 1'b1, 3, 5);
        period("R6 alternate new low count", 1'b0);
        period("R4 back to primary", 1'b0);
        stop();
        wr(3, 4);

        // R7: zero phases skipped
        wr(0, 0); wr(1, 3);
        start(1'b0, 1'b0);
        period("R7 zero high count", 1'b0);
        period("R7 zero high count", 1'b0);
        stop();
        wr(0, 2); wr(1, 0);
        start(1'b0, 1'b0);
        period("R7 zero low count", 1'b0);
        period("R7 zero low count", 1'b0);
        stop();

        // R9: status flag
        wr(3, 0);
        fsk_mode = 1'b1; alt_sel = 1'b0;
        @(negedge clk);
        chk(cfg_err === 1'b0, "R9 flag idle while disabled", int'(cfg_err), 0);
        @(posedge clk); #1;
        gen_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(cfg_err === 1'b1, "R9 flag with zero alternate count", int'(cfg_err), 1);
        @(posedge clk); #1;
        fsk_mode = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(cfg_err === 1'b0, "R9 flag clear in timing mode", int'(cfg_err), 0);
        @(posedge clk); #1;
        gen_en = 1'b0;
        @(posedge clk); #1;
        wr(3, 4);
        fsk_mode = 1'b1;
        gen_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(cfg_err === 1'b0, "R9 flag clear with nonzero counts", int'(cfg_err), 0);
        @(posedge clk); #1;
        gen_en = 1'b0;
        @(posedge clk); #1;

        // R8: alternate counts survive reset, primary cleared (R1)
        rst = 1'b1;
        wr(2, 7);
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        sh[0] = 0; sh[1] = 0;
        start(1'b1, 1'b1);
        period("R8 alternate kept through reset", 1'b1);
        period("R8 alternate kept through reset", 1'b0);
        period("R1 primary zero after second reset", 1'b0);
        stop();

        summary();
    end

endmodule